// File: doc/BRIEF.md
# Numerically Controlled Square-Wave Tick Generator

This block turns a fixed reference clock into a square wave whose frequency is set by a 16-bit tuning word. Every reference cycle a phase accumulator grows by an effective increment. The increment is the tuning word itself when the word lies below half of full scale. Otherwise it is the word's 16-bit two's complement, so the frequency response is symmetric about the midpoint. The output frequency is the increment divided by 2^16, multiplied by the reference frequency. For example, a 27 MHz reference with an increment of 1024 gives about 421.9 kHz.

Software loads the tuning word one byte at a time. Writing the upper byte only stages it. Writing the lower byte commits both bytes together, so the accumulator never adds a half-updated word.

Besides the square wave, the block emits a one-cycle strobe whenever the square wave rises. A following duty-cycle stage can use this strobe as its count enable. Tuning words from 1 up to 32768 are the useful range when the block drives such a stage.

Top module: `nco_tick_gen`

## Requirements
- R1: While reset is high, and in the first cycle after reset releases, `sq_out` and `rise_stb` are 0. Reset also sets the accumulator, the staged upper byte and the committed word to 0.
- R2: A cycle with `wr_hi`=1 and `wr_lo`=0 only stages `wr_data` as bits 15:8. The increment in use does not change.
- R3: A cycle with `wr_lo`=1 commits the word {staged upper byte, `wr_data`} with `wr_data` as bits 7:0. The accumulator adds the new increment from the next cycle on.
- R4: When `wr_hi` and `wr_lo` are both 1 in one cycle, `wr_data` becomes both bytes of the committed word.
- R5: A committed word below 0x8000 is used unchanged as the increment.
- R6: A committed word at or above 0x8000 is replaced by its 16-bit two's complement. 0x8000 stays 0x8000 and 0xFFFF becomes 1.
- R7: The accumulator adds the increment on every reference edge, modulo 2^16. `sq_out` is its most significant bit.
- R8: `rise_stb` is 1 for exactly the cycles in which `sq_out` has just gone from 0 to 1.
- R9: A power-of-two word 2^k (k below 15) starting from a zero accumulator keeps `sq_out` high for exactly 2^(15-k) of every 2^(16-k) cycles, with one strobe per period.
- R10: Word 0x8000 makes `sq_out` toggle on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_hi | input | 1 | Stage `wr_data` as the upper byte of the word |
| wr_lo | input | 1 | Take `wr_data` as the lower byte and commit the word |
| wr_data | input | 8 | Byte write data |
| sq_out | output | 1 | Square-wave output (accumulator MSB) |
| rise_stb | output | 1 | One-cycle pulse on each rising edge of `sq_out` |

## Verification
Two events can land in the same cycle: a lower-byte commit that changes the increment, and an accumulator wrap that raises `sq_out` and fires the strobe. Random byte writes are scattered densely over a running accumulator, so commits regularly coincide with rising edges and with simultaneous upper/lower writes. A bench model that applies the old increment at the commit edge and the new one afterwards judges every cycle. This catches any design that commits a cycle early or late.

// File: rtl/nco_pkg.sv
package nco_pkg;
   localparam int unsigned DEF_BYTE_W = 8;
   localparam int unsigned DEF_WORD_W = 2 * DEF_BYTE_W;

   typedef enum logic [1:0] {
      FOLD_NONE = 2'd0,
      FOLD_TWOS = 2'd1
   } fold_mode_e;
endpackage

// File: rtl/nco_word_regs.sv
module nco_word_regs #(
   parameter int unsigned BYTE_W = nco_pkg::DEF_BYTE_W,
   localparam int unsigned WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [WORD_W-1:0] word_q
);
   logic [BYTE_W-1:0] hi_q;
   logic [BYTE_W-1:0] hi_next;

   assign hi_next = wr_hi ? wr_data : hi_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q   <= '0;
         word_q <= '0;
      end else begin
         hi_q <= hi_next;
         if (wr_lo) begin
            word_q <= {hi_next, wr_data};
         end
      end
   end
endmodule

// File: rtl/nco_fold.sv
module nco_fold #(
   parameter int unsigned        WORD_W = nco_pkg::DEF_WORD_W,
   parameter nco_pkg::fold_mode_e MODE  = nco_pkg::FOLD_TWOS
) (
   input  logic [WORD_W-1:0] word,
   output logic [WORD_W-1:0] inc
);
   generate
      if (MODE == nco_pkg::FOLD_TWOS) begin : g_twos
         logic [WORD_W-1:0] neg;
         assign neg = (~word) + {{(WORD_W-1){1'b0}}, 1'b1};
         assign inc = word[WORD_W-1] ? neg : word;
      end else begin : g_raw
         assign inc = word;
      end
   endgenerate
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
   parameter int unsigned ACC_W = nco_pkg::DEF_WORD_W,
   localparam int unsigned MSB  = ACC_W - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] inc,
   output logic             sq,
   output logic             stb
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_next;
   logic             stb_q;

   assign acc_next = acc_q + inc;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         stb_q <= 1'b0;
      end else begin
         acc_q <= acc_next;
         stb_q <= acc_next[MSB] & ~acc_q[MSB];
      end
   end

   assign sq  = acc_q[MSB];
   assign stb = stb_q;
endmodule

// File: rtl/nco_tick_gen.sv
module nco_tick_gen #(
   parameter int unsigned         BYTE_W = nco_pkg::DEF_BYTE_W,
   parameter nco_pkg::fold_mode_e FOLD   = nco_pkg::FOLD_TWOS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              sq_out,
   output logic              rise_stb
);
   localparam int unsigned WORD_W = 2 * BYTE_W;

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("nco_tick_gen: BYTE_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] inc_w;

   nco_word_regs #(.BYTE_W(BYTE_W)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_hi   (wr_hi),
      .wr_lo   (wr_lo),
      .wr_data (wr_data),
      .word_q  (word_q)
   );

   nco_fold #(.WORD_W(WORD_W), .MODE(FOLD)) u_fold (
      .word (word_q),
      .inc  (inc_w)
   );

   nco_accum #(.ACC_W(WORD_W)) u_acc (
      .clk (clk),
      .rst (rst),
      .inc (inc_w),
      .sq  (sq_out),
      .stb (rise_stb)
   );
endmodule

// File: rtl/nco_tick_chk.sv
module nco_tick_chk #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned WORD_W = 2 * BYTE_W
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_hi,
   input logic              wr_lo,
   input logic [BYTE_W-1:0] wr_data,
   input logic              sq_out,
   input logic              rise_stb,
   input logic [WORD_W-1:0] word_q,
   input logic [WORD_W-1:0] inc_w
);
   localparam logic [WORD_W-1:0] HALF = {1'b1, {(WORD_W-1){1'b0}}};

   AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!sq_out && !rise_stb)); // R1
   AST_HI_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
      (wr_hi && !wr_lo) |=> $stable(word_q)); // R2
   AST_LO_COMMIT: assert property (@(posedge clk) disable iff (rst)
      wr_lo |=> (word_q[BYTE_W-1:0] == $past(wr_data))); // R3
   AST_BOTH_BYTES: assert property (@(posedge clk) disable iff (rst)
      (wr_hi && wr_lo) |=> (word_q[WORD_W-1:BYTE_W] == $past(wr_data))); // R4
   AST_INC_FOLDED: assert property (@(posedge clk) disable iff (rst)
      inc_w <= HALF); // R6
   AST_STB_ON_RISE: assert property (@(posedge clk) disable iff (rst)
      rise_stb |-> (sq_out && !$past(sq_out))); // R8
   AST_RISE_HAS_STB: assert property (@(posedge clk) disable iff (rst)
      (sq_out && !$past(sq_out)) |-> rise_stb); // R8
endmodule

bind nco_tick_gen nco_tick_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wr_hi    (wr_hi),
   .wr_lo    (wr_lo),
   .wr_data  (wr_data),
   .sq_out   (sq_out),
   .rise_stb (rise_stb),
   .word_q   (word_q),
   .inc_w    (inc_w)
);

// File: tb/tb_nco_tick_gen.sv
`timescale 1ns/1ps
module tb_nco_tick_gen;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_hi = 1'b0;
   logic       wr_lo = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       sq_out;
   logic       rise_stb;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0]  m_hi;
   logic [15:0] m_word;
   logic [15:0] m_acc;
   logic        m_stb;

   always #2.5 clk = ~clk;

   nco_tick_gen dut (
      .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo),
      .wr_data(wr_data), .sq_out(sq_out), .rise_stb(rise_stb)
   );

   function automatic logic [15:0] fold_word(input logic [15:0] w);
      return w[15] ? (16'h0000 - w) : w;
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_int(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // one reference cycle: drive at negedge, update model at the edge, compare after it
   task automatic cyc(input string tag, input logic h, input logic l, input logic [7:0] d);
      logic [7:0]  hn;
      logic [15:0] an;
      @(negedge clk);
      wr_hi = h; wr_lo = l; wr_data = d;
      @(posedge clk);
      #1;
      hn = h ? d : m_hi;
      an = m_acc + fold_word(m_word);
      m_stb = an[15] & ~m_acc[15];
      m_acc = an;
      m_hi = hn;
      if (l) m_word = {hn, d};
      check({tag, " sq_out"}, sq_out, m_acc[15]);
      check({tag, " rise_stb"}, rise_stb, m_stb);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; wr_hi = 0; wr_lo = 0; wr_data = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset sq_out", sq_out, 1'b0);
      check("R1 reset rise_stb", rise_stb, 1'b0);
      @(negedge clk);
      rst = 1'b0;
      m_hi = 0; m_word = 0; m_acc = 0; m_stb = 0;
   endtask

   task automatic load(input string tag, input logic [15:0] w);
      cyc(tag, 1'b1, 1'b0, w[15:8]);
      cyc(tag, 1'b0, 1'b1, w[7:0]);
   endtask

   // count highs and rises over n idle cycles
   task automatic measure(input string tag, input int n, output int highs, output int rises);
      highs = 0; rises = 0;
      for (int i = 0; i < n; i++) begin
         cyc(tag, 1'b0, 1'b0, 8'h00);
         highs += sq_out;
         rises += rise_stb;
      end
   endtask

   initial begin
      int h, r;
      logic prev;
      void'($urandom(32'd20240611));
      do_reset();

      // R1: a zero word holds the output low
      measure("R1 idle", 20, h, r);
      check_int("R1 idle highs", h, 0);

      // R9 / R5: 0x0400 -> period 64, 32 high, one strobe
      load("R5 load", 16'h0400);
      measure("R9 duty", 64, h, r);
      check_int("R9 highs per period", h, 32);
      check_int("R9 strobes per period", r, 1);

      // R6: 0xC000 folds to 0x4000 -> period 4, 2 high
      do_reset();
      load("R6 load", 16'hC000);
      measure("R6 folded", 16, h, r);
      check_int("R6 highs 0xC000", h, 8);
      check_int("R6 strobes 0xC000", r, 4);

      // R6: 0xFFFF folds to 1 -> stays low for a long time
      do_reset();
      load("R6 load", 16'hFFFF);
      measure("R6 min", 200, h, r);
      check_int("R6 highs 0xFFFF", h, 0);

      // R10: 0x8000 toggles every cycle
      do_reset();
      load("R10 load", 16'h8000);
      prev = sq_out;
      for (int i = 0; i < 12; i++) begin
         cyc("R10 run", 1'b0, 1'b0, 8'h00);
         check("R10 toggle", sq_out, ~prev);
         prev = sq_out;
      end

      // R2: staging the upper byte alone keeps the rate
      do_reset();
      load("R2 load", 16'h0800);
      cyc("R2 stage", 1'b1, 1'b0, 8'h40);
      measure("R2 hold", 32, h, r);
      check_int("R2 highs kept", h, 16);

      // R4: simultaneous writes fill both bytes (0x2020)
      cyc("R4 both", 1'b1, 1'b1, 8'h20);
      measure("R4 run", 64, h, r);

      // R3 / R7 / R8: dense random writes against the model
      for (int i = 0; i < 6000; i++) begin
         logic hh, ll;
         hh = ($urandom % 4) == 0;
         ll = ($urandom % 5) == 0;
         cyc("R3 R7 R8 random", hh, ll, 8'($urandom));
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(5 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule